// File: doc/BRIEF.md
# Byte-on-one-digit display driver

This block turns an 8-bit value into the pattern for one 8-bit output port. The port shows either the raw byte or a single seven-segment digit with a decimal point. A source select chooses between the accumulator and the ALU result that an execute step would load. A format select chooses between binary and seven-segment output.

In seven-segment format, one digit has to show a whole byte. It does this by showing the high nibble and the low nibble in turn. The decimal point is lit only while the low nibble is on the digit. The nibble shown is chosen by a small state machine that has three states:

- `S_HI`: auto mode, showing the upper nibble.
- `S_LO`: auto mode, showing the lower nibble.
- `S_HOLD`: manual mode.

The state machine has these transitions:

- `T_FLIP`: between `S_HI` and `S_LO`, taken on each timer tick.
- `T_ENTER_HOLD`: from any state into `S_HOLD`, taken whenever manual mode is requested.
- `T_RESUME`: from `S_HOLD` back to `S_HI`, taken when manual mode is released.

A free-running timer produces the ticks. Its half period is a parameter, sized by default for a 10 kHz clock. The carry and zero flags of the datapath are passed through to two status outputs.

Top module: `byte_digit_display`

## Requirements
- R1: With `fmt_bin`=1, `disp_out` equals the selected byte one clock after the inputs are applied.
- R2: With `src_alu`=0 the selected byte is `acc_val`; with `src_alu`=1 it is `alu_val`.
- R3: With `fmt_bin`=0, `disp_out[6:0]` carries segments a..g (bit 0 = a), active high, with these glyphs:
  - 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07
  - 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71
  
  `disp_out[7]` is the decimal point. It is 1 exactly when the lower nibble is shown.
- R4: With `nib_manual`=1, `nib_pick_hi`=0 shows the lower nibble with the point lit. `nib_pick_hi`=1 shows the upper nibble with the point dark.
- R5: With `nib_manual`=0, the digit starts on the upper nibble after reset. It flips between the nibbles at every tick of a free-running counter. The first tick comes `HALF_PERIOD` clocks after reset, and the ticks follow every `HALF_PERIOD` clocks. When manual mode is released, the digit restarts on the upper nibble and flips at the next tick.
- R6: `carry_led` and `zero_led` equal `carry_in` and `zero_in` one clock earlier.
- R7: While `rst_n` is low, `disp_out`, `carry_led` and `zero_led` are 0.
- R8: All outputs are registered, so a change of any input appears at the outputs after exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_val | input | 8 | Accumulator value |
| alu_val | input | 8 | Pending ALU result |
| src_alu | input | 1 | 0: show accumulator, 1: show ALU result |
| fmt_bin | input | 1 | 0: seven-segment, 1: binary |
| nib_manual | input | 1 | 1: nibble chosen by hand |
| nib_pick_hi | input | 1 | Manual choice: 1 upper, 0 lower |
| carry_in | input | 1 | Carry flag from datapath |
| zero_in | input | 1 | Zero flag from datapath |
| disp_out | output | 8 | Binary byte or {dp, g..a} |
| carry_led | output | 1 | Registered carry flag |
| zero_led | output | 1 | Registered zero flag |

## Verification
The assertions assume that every input is synchronous to `clk` and stays stable between rising edges. They also assume that the inputs hold defined values from time zero, so that a one-cycle look back after reset never sees unknowns. The stimulus changes inputs only on falling edges and starts them all at zero. The auto-toggle window is shortened through `HALF_PERIOD` so that several flips, and manual entries and exits in the middle of a period, fit into a short run.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int SEG_W  = 7;

    typedef enum logic [1:0] {
        S_HI   = 2'd0,
        S_LO   = 2'd1,
        S_HOLD = 2'd2
    } nib_state_t;

    function automatic logic [SEG_W-1:0] glyph_of(input logic [NIB_W-1:0] nib);
        logic [SEG_W-1:0] g;
        unique case (nib)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/nib_timer.sv
module nib_timer #(
    parameter int HALF_PERIOD = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R5

endmodule

// File: rtl/nib_fsm.sv
module nib_fsm
    import disp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic manual,
    output logic auto_lo
);
    nib_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_HI:   if (manual) state_nx = S_HOLD;      // T_ENTER_HOLD
                    else if (tick) state_nx = S_LO;     // T_FLIP
            S_LO:   if (manual) state_nx = S_HOLD;      // T_ENTER_HOLD
                    else if (tick) state_nx = S_HI;     // T_FLIP
            S_HOLD: if (!manual) state_nx = S_HI;       // T_RESUME
            default: state_nx = S_HI;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_HI;
        else
            state <= state_nx;
    end

    always_comb begin
        auto_lo = (state == S_LO);
    end

    AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        manual |=> (state == S_HOLD)); // R4
    AST_RESUME_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && !manual) |=> (state == S_HI)); // R5
    AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_HOLD && !manual && !tick) |=> $stable(state)); // R5

endmodule

// File: rtl/nib_encoder.sv
module nib_encoder
    import disp_pkg::*;
(
    input  logic [BYTE_W-1:0] value,
    input  logic              show_lo,
    input  logic              fmt_bin,
    output logic [BYTE_W-1:0] word
);
    logic [NIB_W-1:0] nib;

    always_comb begin
        nib  = show_lo ? value[NIB_W-1:0] : value[BYTE_W-1:NIB_W];
        word = fmt_bin ? value : {show_lo, glyph_of(nib)};
    end

    AST_BIN_PASSTHRU: assert final (!fmt_bin || word == value); // R1

endmodule

// File: rtl/byte_digit_display.sv
module byte_digit_display
    import disp_pkg::*;
#(
    parameter int HALF_PERIOD = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] acc_val,
    input  logic [BYTE_W-1:0] alu_val,
    input  logic              src_alu,
    input  logic              fmt_bin,
    input  logic              nib_manual,
    input  logic              nib_pick_hi,
    input  logic              carry_in,
    input  logic              zero_in,
    output logic [BYTE_W-1:0] disp_out,
    output logic              carry_led,
    output logic              zero_led
);
    logic              tick;
    logic              auto_lo;
    logic              show_lo;
    logic [BYTE_W-1:0] sel_val;
    logic [BYTE_W-1:0] word;

    nib_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    nib_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .manual  (nib_manual),
        .auto_lo (auto_lo)
    );

    always_comb begin
        sel_val = src_alu ? alu_val : acc_val;
        show_lo = nib_manual ? !nib_pick_hi : auto_lo;
    end

    nib_encoder u_enc (
        .value   (sel_val),
        .show_lo (show_lo),
        .fmt_bin (fmt_bin),
        .word    (word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_out  <= '0;
            carry_led <= 1'b0;
            zero_led  <= 1'b0;
        end else begin
            disp_out  <= word;
            carry_led <= carry_in;
            zero_led  <= zero_in;
        end
    end

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_BIN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fmt_bin) |=> disp_out == $past(src_alu ? alu_val : acc_val)); // R2
    AST_FLAG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> (carry_led == $past(carry_in) && zero_led == $past(zero_in))); // R6
    AST_DP_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !fmt_bin && nib_manual && !nib_pick_hi) |=> disp_out[7]); // R3
    AST_DP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !fmt_bin && nib_manual && nib_pick_hi) |=> !disp_out[7]); // R4

endmodule

// File: tb/byte_digit_display_tb.sv
module byte_digit_display_tb;
    localparam int HP = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_val = 8'h00;
    logic [7:0] alu_val = 8'h00;
    logic       src_alu = 1'b0;
    logic       fmt_bin = 1'b0;
    logic       nib_manual = 1'b0;
    logic       nib_pick_hi = 1'b0;
    logic       carry_in = 1'b0;
    logic       zero_in = 1'b0;
    logic [7:0] disp_out;
    logic       carry_led;
    logic       zero_led;

    int checks = 0;
    int failures = 0;

    byte_digit_display #(.HALF_PERIOD(HP)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_val(acc_val), .alu_val(alu_val),
        .src_alu(src_alu), .fmt_bin(fmt_bin), .nib_manual(nib_manual),
        .nib_pick_hi(nib_pick_hi), .carry_in(carry_in), .zero_in(zero_in),
        .disp_out(disp_out), .carry_led(carry_led), .zero_led(zero_led)
    );

    always #2 clk = ~clk;

    function automatic logic [6:0] seg_ref(input logic [3:0] d);
        case (d)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
            4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
            4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    // behavioural model: counter position, and phase 0 upper / 1 lower / 2 manual
    int         m_cnt = 0;
    int         m_phase = 0;
    logic [7:0] exp_out = 8'h00;
    logic       exp_c = 1'b0;
    logic       exp_z = 1'b0;
    string      exp_tag = "R7";
    bit         cmp_en = 1'b0;

    always @(posedge clk) begin
        logic       lo;
        logic [7:0] v;
        logic [3:0] n;
        bit         t;
        if (!rst_n) begin
            m_cnt = 0; m_phase = 0;
            exp_out = 8'h00; exp_c = 1'b0; exp_z = 1'b0;
            exp_tag = "R7";
        end else begin
            lo = nib_manual ? !nib_pick_hi : (m_phase == 1);
            v  = src_alu ? alu_val : acc_val;
            n  = lo ? v[3:0] : v[7:4];
            exp_out = fmt_bin ? v : {lo, seg_ref(n)};
            exp_c = carry_in; exp_z = zero_in;
            if (fmt_bin)         exp_tag = src_alu ? "R2,R8" : "R1,R8";
            else if (nib_manual) exp_tag = "R3,R4";
            else                 exp_tag = "R3,R5";
            t = (m_cnt == HP - 1);
            m_cnt = t ? 0 : m_cnt + 1;
            if (nib_manual)        m_phase = 2;
            else if (m_phase == 2) m_phase = 0;
            else if (t)            m_phase = 1 - m_phase;
        end
        cmp_en = 1'b1;
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (disp_out !== exp_out) begin
                failures++;
                $display("FAIL %s disp_out actual=%h expected=%h at %0t", exp_tag, disp_out, exp_out, $time);
            end
            checks++;
            if (carry_led !== exp_c || zero_led !== exp_z) begin
                failures++;
                $display("FAIL R6 flags actual=%b%b expected=%b%b at %0t",
                         carry_led, zero_led, exp_c, exp_z, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        // R7: outputs held at zero during reset
        checks++;
        if (disp_out !== 8'h00 || carry_led !== 1'b0 || zero_led !== 1'b0) begin
            failures++;
            $display("FAIL R7 reset actual=%h%b%b expected=0000", disp_out, carry_led, zero_led);
        end
        rst_n = 1'b1;
        // R5: auto mode from reset, upper first, flip every HP clocks
        acc_val = 8'hC4;
        step(3 * HP + 2);
        // R1, R2, R6: binary format with both sources
        fmt_bin = 1'b1;
        for (int i = 0; i < 24; i++) begin
            acc_val  = 8'(i * 37 + 5);
            alu_val  = 8'(255 - i * 11);
            src_alu  = i[0];
            carry_in = i[1];
            zero_in  = i[2];
            step(1);
        end
        // R3, R4: every digit in manual mode, both nibbles
        fmt_bin = 1'b0;
        nib_manual = 1'b1;
        for (int d = 0; d < 16; d++) begin
            acc_val = {4'(d), 4'(15 - d)};
            alu_val = {4'(15 - d), 4'(d)};
            src_alu = d[0];
            nib_pick_hi = 1'b0;
            step(1);
            nib_pick_hi = 1'b1;
            step(1);
        end
        // R5: release manual in the middle of a period, then re-enter
        nib_manual = 1'b0;
        acc_val = 8'h5A; src_alu = 1'b0;
        step(2 * HP + 3);
        nib_manual = 1'b1; nib_pick_hi = 1'b0;
        step(2);
        nib_manual = 1'b0;
        step(3 * HP);
        // R8: format toggled each cycle during auto toggling
        for (int i = 0; i < 20; i++) begin
            fmt_bin = i[0];
            alu_val = 8'(i * 13);
            src_alu = i[1];
            step(1);
        end
        // R7: reset again mid run
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        fmt_bin = 1'b0; src_alu = 1'b0; acc_val = 8'hDB;
        step(2 * HP + 4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule